// File: doc/BRIEF.md
# Read-Triggered Delayed RAM Write Controller

This block sits on a cartridge port that carries address lines and a select line, but no data path from the processor and no processor phase clock. It turns plain read accesses into RAM writes. When the processor reads any location in a reserved 256-byte window of the cartridge space, the block takes the low eight bits of that address as the byte to be stored. A fixed number of clock ticks later, whatever address is on the bus becomes the write target. The block then raises a single write strobe carrying that address and the stored byte.

The clock is free-running and matched to the processor cycle rate, so one tick equals one bus access. The block cannot tell opcode fetches from operand reads. Its behaviour depends only on the addresses seen and on the ticks elapsed since the last window access. Software therefore arms a write with an indexed read into the window and places the target access exactly the set number of cycles later. Page-crossing indexed reads produce an early, unfixed read, and that read is what arms the write.

Top module: `rdw_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are zero after that edge, and no write strobe appears until a window access has been made after reset.
- R2: A window access is a tick with `cart_sel` high and `cart_addr[12:8]` equal to the window tag (default 0). It arms a write whose data byte is `cart_addr[7:0]` of that access.
- R3: The write target is the access exactly `DELAY` ticks (default 6) after the arming access. `ram_we` is high for the one clock cycle after the edge that samples that access, with `ram_waddr` equal to its address and `ram_wdata` equal to the armed byte.
- R4: Each arming produces at most one write. `ram_we` is never high in two consecutive cycles, and no strobe appears without a preceding arming.
- R5: If `cart_sel` is low at the target tick, no write is made, the armed write is dropped, and later ticks produce no write from it.
- R6: A window access while a write is armed, including one at the target tick itself, replaces the armed byte and restarts the delay from that access. The last window access wins.
- R7: An access whose address lies in the window but with `cart_sel` low neither arms nor disturbs an armed write.
- R8: An indexed page-crossing read sequence that touches window offset 0xFE and then an address outside the window arms with byte 0xFE, with the delay counted from the window read.
- R9: `ram_waddr` and `ram_wdata` change only in cycles where `ram_we` is high, and otherwise hold the values of the last write (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at the processor cycle rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cart_addr | input | 13 | Cartridge address for the current tick |
| cart_sel | input | 1 | High when the current access targets the cartridge |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_waddr | output | 13 | RAM write address, valid with `ram_we` |
| ram_wdata | output | 8 | RAM write data, valid with `ram_we` |

## Verification
Every output is registered. The effect of the access presented in one cycle therefore appears right after the next rising edge. A write armed at tick t shows on the ports in the cycle after the edge that samples tick t+`DELAY`. The bench drives each access on a falling edge and updates its own tick-count model for the edge that follows. It compares all three outputs on the next falling edge, exactly one register stage after the access. The directed sequences also count strobes across a whole instruction sequence, so a late, early or duplicated write shows up even where the per-cycle comparison already caught it.

// File: rtl/rdw_pkg.sv
// Package: shared widths and types for the read-triggered write controller.
// Assumes a 13-bit cartridge address whose low byte carries the write data.
package rdw_pkg;
    localparam int unsigned CART_AW  = 13;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned TAG_W    = CART_AW - DATA_W;

    typedef logic [CART_AW-1:0] cart_addr_t;
    typedef logic [DATA_W-1:0]  ram_data_t;
    typedef logic [TAG_W-1:0]   win_tag_t;
endpackage

// File: rtl/rdw_window_dec.sv
// Module: decodes a window hit from the cartridge bus.
// Assumes the window is the 256-byte page selected by the upper address bits.
module rdw_window_dec
    import rdw_pkg::*;
#(
    parameter win_tag_t WIN_TAG = '0
) (
    input  cart_addr_t cart_addr,
    input  logic       cart_sel,
    output logic       hit,
    output ram_data_t  low_byte
);
    // Split the address into the window tag and the data byte.
    always_comb begin
        hit      = cart_sel && (cart_addr[CART_AW-1:DATA_W] == WIN_TAG);
        low_byte = cart_addr[DATA_W-1:0];
    end
endmodule

// File: rtl/rdw_capture_reg.sv
// Module: holds the byte taken from the most recent window access.
// Assumes the load pulse comes from the window decoder in the same cycle.
module rdw_capture_reg
    import rdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  ram_data_t din,
    output ram_data_t dout
);
    // Latch the low address byte on every window access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/rdw_commit_timer.sv
// Module: counts the ticks from an arming access to the target tick.
// Assumes DELAY >= 1; a reload on the target tick suppresses the fire.
module rdw_commit_timer #(
    parameter int unsigned DELAY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic fire
);
    localparam int unsigned CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CNT_W-1:0] START = CNT_W'(DELAY - 1);

    logic             armed;
    logic [CNT_W-1:0] cnt;

    // Fire at the target tick unless a new arming access replaces it.
    always_comb begin
        fire = armed && (cnt == '0) && !load;
    end

    // Load on arming, count down, and disarm once the target tick passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            armed <= 1'b1;
            cnt   <= START;
        end else if (armed) begin
            if (cnt == '0) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdw_write_port.sv
// Module: registers the RAM write strobe, address and data.
// Assumes commit is high for at most one tick per arming.
module rdw_write_port
    import rdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  cart_addr_t tgt_addr,
    input  ram_data_t  tgt_data,
    output logic       ram_we,
    output cart_addr_t ram_waddr,
    output ram_data_t  ram_wdata
);
    // Drive a one-cycle strobe and hold address and data between writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_waddr <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= commit;
            if (commit) begin
                ram_waddr <= tgt_addr;
                ram_wdata <= tgt_data;
            end
        end
    end
endmodule

// File: rtl/rdw_ctrl.sv
// Module: top of the read-triggered delayed RAM write controller.
// A window read arms a write of its low address byte; the access DELAY
// ticks later becomes the target. Assumes clk matches the processor rate.
module rdw_ctrl
    import rdw_pkg::*;
#(
    parameter int unsigned DELAY   = 6,
    parameter win_tag_t    WIN_TAG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CART_AW-1:0] cart_addr,
    input  logic              cart_sel,
    output logic              ram_we,
    output logic [CART_AW-1:0] ram_waddr,
    output logic [DATA_W-1:0]  ram_wdata
);
    logic      win_hit;
    ram_data_t win_byte;
    ram_data_t held_byte;
    logic      tgt_tick;
    logic      commit;

    rdw_window_dec #(.WIN_TAG(WIN_TAG)) dec_i (
        .cart_addr (cart_addr),
        .cart_sel  (cart_sel),
        .hit       (win_hit),
        .low_byte  (win_byte)
    );

    rdw_capture_reg cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_hit),
        .din   (win_byte),
        .dout  (held_byte)
    );

    rdw_commit_timer #(.DELAY(DELAY)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_hit),
        .fire  (tgt_tick)
    );

    // Write only when the target access is a cartridge access.
    always_comb begin
        commit = tgt_tick && cart_sel;
    end

    rdw_write_port wp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .tgt_addr  (cart_addr),
        .tgt_data  (held_byte),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );
endmodule

// File: rtl/rdw_ctrl_chk.sv
// Module: property checker bound to rdw_ctrl.
// Tracks ticks since the last window access with its own saturating counter.
module rdw_ctrl_chk
    import rdw_pkg::*;
#(
    parameter int unsigned DELAY   = 6,
    parameter win_tag_t    WIN_TAG = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CART_AW-1:0] cart_addr,
    input logic               cart_sel,
    input logic               ram_we,
    input logic [CART_AW-1:0] ram_waddr,
    input logic [DATA_W-1:0]  ram_wdata
);
    localparam int unsigned SW = $clog2(DELAY + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic            seen_win;
    logic [SW-1:0]   since;
    logic [DATA_W-1:0] last_byte;
    logic            win_now;

    always_comb begin
        win_now = cart_sel && (cart_addr[CART_AW-1:DATA_W] == WIN_TAG);
    end

    // Independent record of the last window access and ticks elapsed since.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_win  <= 1'b0;
            since     <= SMAX;
            last_byte <= '0;
        end else if (win_now) begin
            seen_win  <= 1'b1;
            since     <= '0;
            last_byte <= cart_addr[DATA_W-1:0];
        end else if (since != SMAX) begin
            since <= since + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ram_we && ram_waddr == '0 && ram_wdata == '0));

    // R3
    delay_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (seen_win && since == SW'(DELAY)));

    // R2
    data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_wdata == last_byte));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    // R5
    sel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(cart_sel));

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we |-> ($stable(ram_waddr) && $stable(ram_wdata)));
endmodule

bind rdw_ctrl rdw_ctrl_chk #(.DELAY(DELAY), .WIN_TAG(WIN_TAG)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cart_addr (cart_addr),
    .cart_sel  (cart_sel),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
);

// File: tb/rdw_ctrl_tb_top.sv
// Bench for rdw_ctrl: directed instruction sequences plus seeded random bus
// traffic, checked against a tick-count model derived from the requirements.
module rdw_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  DELAY      = 6;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cart_addr = '0;
    logic        cart_sel = 1'b0;
    logic        ram_we;
    logic [12:0] ram_waddr;
    logic [7:0]  ram_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model state: tick-based, independent of the design structure.
    int        tick = 0;
    int        cap_tick = 0;
    bit        armed = 1'b0;
    logic [7:0]  cap_data = '0;
    logic        exp_we = 1'b0;
    logic [12:0] exp_addr = '0;
    logic [7:0]  exp_data = '0;
    int        wr_count = 0;

    rdw_ctrl #(.DELAY(DELAY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cart_addr (cart_addr),
        .cart_sel  (cart_sel),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit in_window(logic [12:0] a, logic s);
        return s && (a[12:8] == 5'd0);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model for the edge that samples this access.
    task automatic model_step(logic [12:0] a, logic s);
        tick++;
        exp_we = 1'b0;
        if (in_window(a, s)) begin
            armed    = 1'b1;
            cap_tick = tick;
            cap_data = a[7:0];
        end else if (armed && (tick - cap_tick) == DELAY) begin
            armed = 1'b0;
            if (s) begin
                exp_we   = 1'b1;
                exp_addr = a;
                exp_data = cap_data;
            end
        end
    endtask

    // One bus tick: drive on the falling edge, check on the next one.
    task automatic step(logic [12:0] a, logic s);
        cart_addr = a;
        cart_sel  = s;
        model_step(a, s);
        @(negedge clk);
        if (ram_we) wr_count++;
        check(exp_we ? "R3 strobe" : "R4 strobe", int'(ram_we), int'(exp_we));
        check("R9 waddr", int'(ram_waddr), int'(exp_addr));
        check("R2 wdata", int'(ram_wdata), int'(exp_data));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(13'h0A00 + 13'(i), 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int w0;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // R1: outputs quiet while reset is held, even with window traffic.
        for (int i = 0; i < 4; i++) begin
            cart_addr = 13'h0012; cart_sel = 1'b1;
            @(negedge clk);
            check("R1 we", int'(ram_we), 0);
            check("R1 waddr", int'(ram_waddr), 0);
            check("R1 wdata", int'(ram_wdata), 0);
        end
        rst_n = 1'b1;
        idle(8);
        check("R1 no write after reset", wr_count, 0);

        // R3/R2: cmp $F000,X (X=FF); nop; lda $F800.
        w0 = wr_count;
        step(13'h0900, 1); step(13'h0901, 1); step(13'h0902, 1); step(13'h00FF, 1);
        step(13'h0903, 1); step(13'h0904, 1);
        step(13'h0904, 1); step(13'h0905, 1); step(13'h0906, 1); step(13'h0800, 1);
        check("R3 seqA addr", int'(ram_waddr), 'h800);
        check("R2 seqA data", int'(ram_wdata), 'hFF);
        idle(4);
        check("R4 seqA one write", wr_count - w0, 1);

        // R3: cmp $F000,Y (Y=FF); lda ($80,X) with zero-page reads off-cart.
        w0 = wr_count;
        step(13'h0910, 1); step(13'h0911, 1); step(13'h0912, 1); step(13'h00FF, 1);
        step(13'h0913, 1); step(13'h0914, 1);
        step(13'h0080, 0); step(13'h0080, 0); step(13'h0081, 0); step(13'h0800, 1);
        check("R3 seqB addr", int'(ram_waddr), 'h800);
        idle(4);
        check("R4 seqB one write", wr_count - w0, 1);

        // R8: cmp $F0FF,X page cross: false read at offset FE, then 1FE.
        w0 = wr_count;
        step(13'h0920, 1); step(13'h0921, 1); step(13'h0922, 1); step(13'h00FE, 1);
        step(13'h01FE, 1); step(13'h0923, 1); step(13'h0924, 1); step(13'h0925, 1);
        step(13'h0926, 1); step(13'h0800, 1);
        check("R8 page-cross data", int'(ram_wdata), 'hFE);
        idle(4);
        check("R8 one write", wr_count - w0, 1);

        // R5: select low at the target tick drops the write.
        w0 = wr_count;
        step(13'h0033, 1); idle(5); step(13'h0800, 0); idle(10);
        check("R5 dropped", wr_count - w0, 0);

        // R6: second arming restarts the delay and replaces the byte.
        w0 = wr_count;
        step(13'h0011, 1); idle(2); step(13'h0022, 1); idle(5); step(13'h0555, 1);
        check("R6 retrigger data", int'(ram_wdata), 'h22);
        idle(4);
        check("R6 one write", wr_count - w0, 1);

        // R6: window access on the target tick re-arms instead of writing.
        w0 = wr_count;
        step(13'h0044, 1); idle(5); step(13'h0055, 1);
        check("R6 no write on target", wr_count - w0, 0);
        idle(5); step(13'h0666, 1);
        check("R6 override data", int'(ram_wdata), 'h55);

        // R7: window address with select low neither arms nor disturbs.
        idle(4);
        w0 = wr_count;
        step(13'h0077, 0); idle(10);
        check("R7 no arm", wr_count - w0, 0);
        step(13'h0010, 1); step(13'h0900, 1); step(13'h00AA, 0); idle(3); step(13'h0777, 1);
        check("R7 data kept", int'(ram_wdata), 'h10);
        idle(3);

        // Random traffic with a bias toward the window.
        for (int i = 0; i < 4000; i++) begin
            logic [12:0] a;
            logic        s;
            a = 13'($urandom);
            if ($urandom_range(0, 9) < 3) a[12:8] = 5'd0;
            s = ($urandom_range(0, 99) < 85);
            step(a, s);
        end

        // R1: reset in the middle of a pending write clears everything.
        step(13'h0099, 1); step(13'h0900, 1);
        cart_addr = 13'h0901; cart_sel = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 mid reset we", int'(ram_we), 0);
        check("R1 mid reset addr", int'(ram_waddr), 0);
        rst_n = 1'b1;
        armed = 1'b0; exp_addr = '0; exp_data = '0;
        w0 = wr_count;
        idle(10);
        check("R1 pending cleared", wr_count - w0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule